// File: doc/BRIEF.md
# Three-Stage Pipeline Fetch Controller

This block is the front-end control of a small 32-bit RISC core whose pipeline has three stages: fetch, decode and execute. It owns the fetch address and presents it to an instruction memory that returns the addressed word in the same cycle. It keeps a valid bit, an instruction word and an address for the decode and execute slots, and hands the execute stage the value that stage sees when it reads the program counter. That value is the executing instruction's address plus eight.

The execute stage can change the program counter with a taken branch or a direct write. Either change discards the two younger instructions and restarts fetch at the new target. An unmasked interrupt request also redirects fetch, to a vector address supplied from outside. The instruction already in execute is allowed to finish, and the younger ones are abandoned. The block reports where the interrupted program must resume. A stall input freezes the whole pipeline in place.

Top module: `fetch_front`

## Requirements
- R1: While reset is asserted and in the first cycle after release, `dec_valid` and `ex_valid` are 0 and `imem_addr` is 0. With no redirect or stall, the instruction at address 0 is in decode after the second rising edge and in execute after the third.
- R2: `imem_addr` always has bits [1:0] equal to 0. A redirect target or vector with nonzero low bits is used with those two bits cleared. Sequential fetch advances by 4 per unstalled cycle.
- R3: `ex_pc_read` equals `ex_addr` + 8, modulo 2^32, whenever `ex_valid` is 1.
- R4: `redir_valid` high with `ex_valid` high and `stall` low causes the following effects in the next cycle: `imem_addr` equals the aligned target, and both `dec_valid` and `ex_valid` are 0.
- R5: A redirect target reaches decode one cycle after it is issued on `imem_addr` and reaches execute two cycles after. `ex_instr` carries the word the memory returned for `ex_addr`.
- R6: When `irq` is high, `irq_mask` is low, `stall` is low and fetch is active, `irq_ack` is 1 in that cycle. In that cycle `irq_ret_addr` is the decode address if `dec_valid` is 1, and otherwise the current `imem_addr`. In the next cycle `imem_addr` is the aligned `irq_vector`, and decode and execute are invalid.
- R7: With `irq_mask` high, `irq` has no effect: `irq_ack` stays 0 and the pipeline keeps advancing in sequence.
- R8: When a redirect and an interrupt are accepted in the same cycle, `irq_ret_addr` is the aligned redirect target and fetch goes to the aligned vector.
- R9: While `stall` is high, `imem_addr`, the valid bits and the slot addresses hold their values. In that state `irq_ack` is 0, and neither a redirect nor an interrupt is acted on.
- R10: `redir_valid` is ignored while `ex_valid` is 0, and fetch continues in sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| stall | input | 1 | Freeze all stages and the fetch address |
| imem_addr | output | 32 | Fetch address, word aligned |
| imem_req | output | 1 | Fetch active (0 only in the first cycle after reset) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| redir_valid | input | 1 | Execute stage changes the PC (taken branch or PC write) |
| redir_target | input | 32 | New PC value |
| irq | input | 1 | Interrupt request |
| irq_mask | input | 1 | Interrupt disable, active high |
| irq_vector | input | 32 | Fetch address of the interrupt handler |
| irq_ack | output | 1 | Interrupt taken this cycle |
| irq_ret_addr | output | 32 | Address of the first abandoned instruction |
| dec_valid | output | 1 | Decode slot holds an instruction |
| dec_instr | output | 32 | Decode slot instruction |
| dec_addr | output | 32 | Decode slot address |
| ex_valid | output | 1 | Execute slot holds an instruction |
| ex_instr | output | 32 | Execute slot instruction |
| ex_addr | output | 32 | Execute slot address |
| ex_pc_read | output | 32 | PC value seen by the executing instruction |

## Verification
A free-running sweep from reset checks the fill timing, the +4 sequence and the PC read offset at every step, so the slot latencies are separated from the address arithmetic. Redirects are driven to aligned, misaligned and wrap-around targets, and a second redirect is driven into the bubble that follows, which exposes both alignment and the gating by `ex_valid`. Interrupts are raised with decode full, with decode empty, masked, together with a redirect, and during a stall. Each of these cases selects a different source for the return address, or none.

// File: rtl/pf_pkg.sv
package pf_pkg;
  parameter int unsigned ADDR_W  = 32;
  parameter int unsigned INSTR_W = 32;
  localparam int unsigned WORD_BYTES = INSTR_W / 8;
  localparam int unsigned ALIGN_BITS = $clog2(WORD_BYTES);
  localparam int unsigned PC_AHEAD   = 2 * WORD_BYTES;

  typedef logic [ADDR_W-1:0]  addr_t;
  typedef logic [INSTR_W-1:0] instr_t;

  typedef struct packed {
    logic   valid;
    instr_t instr;
    addr_t  addr;
  } slot_t;

  function automatic addr_t word_align(input addr_t a);
    return {a[ADDR_W-1:ALIGN_BITS], {ALIGN_BITS{1'b0}}};
  endfunction
endpackage

// File: rtl/pf_slot_reg.sv
module pf_slot_reg
  import pf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  squash,
  input  slot_t d,
  output slot_t q
);
  logic   valid_q, valid_d;
  instr_t instr_q;
  addr_t  addr_q;

  always_comb begin
    valid_d = squash ? 1'b0 : d.valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
    end else if (advance) begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (advance) begin
      instr_q <= d.instr;
      addr_q  <= d.addr;
    end
  end

  assign q = '{valid: valid_q, instr: instr_q, addr: addr_q};
endmodule

// File: rtl/pf_pc_unit.sv
module pf_pc_unit
  import pf_pkg::*;
#(
  parameter addr_t RESET_ADDR = '0
)(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  advance,
  input  logic  redir_go,
  input  addr_t redir_target,
  input  logic  irq_go,
  input  addr_t irq_vector,
  input  logic  dec_valid,
  input  addr_t dec_addr,
  output addr_t pc,
  output logic  active,
  output addr_t ret_addr
);
  addr_t pc_q, pc_d;
  logic  active_q;

  always_comb begin
    if (redir_go)       ret_addr = word_align(redir_target);
    else if (dec_valid) ret_addr = dec_addr;
    else                ret_addr = pc_q;

    if (irq_go)         pc_d = word_align(irq_vector);
    else if (redir_go)  pc_d = word_align(redir_target);
    else if (active_q)  pc_d = pc_q + addr_t'(WORD_BYTES);
    else                pc_d = pc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_ADDR;
      active_q <= 1'b0;
    end else if (advance) begin
      pc_q     <= pc_d;
      active_q <= 1'b1;
    end
  end

  assign pc     = pc_q;
  assign active = active_q;
endmodule

// File: rtl/fetch_front.sv
module fetch_front
  import pf_pkg::*;
#(
  parameter addr_t RESET_ADDR = '0
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               stall,
  output logic [ADDR_W-1:0]  imem_addr,
  output logic               imem_req,
  input  logic [INSTR_W-1:0] imem_rdata,
  input  logic               redir_valid,
  input  logic [ADDR_W-1:0]  redir_target,
  input  logic               irq,
  input  logic               irq_mask,
  input  logic [ADDR_W-1:0]  irq_vector,
  output logic               irq_ack,
  output logic [ADDR_W-1:0]  irq_ret_addr,
  output logic               dec_valid,
  output logic [INSTR_W-1:0] dec_instr,
  output logic [ADDR_W-1:0]  dec_addr,
  output logic               ex_valid,
  output logic [INSTR_W-1:0] ex_instr,
  output logic [ADDR_W-1:0]  ex_addr,
  output logic [ADDR_W-1:0]  ex_pc_read
);
  localparam int unsigned NSLOT = 3;

  slot_t slot [NSLOT];
  logic  advance, redir_go, irq_go, flush, fetch_on;
  addr_t pc;

  always_comb begin
    advance  = !stall;
    redir_go = advance && redir_valid && slot[NSLOT-1].valid;
    irq_go   = advance && irq && !irq_mask && fetch_on;
    flush    = redir_go || irq_go;
  end

  pf_pc_unit #(.RESET_ADDR(RESET_ADDR)) u_pc (
    .clk          (clk),
    .rst_n        (rst_n),
    .advance      (advance),
    .redir_go     (redir_go),
    .redir_target (redir_target),
    .irq_go       (irq_go),
    .irq_vector   (irq_vector),
    .dec_valid    (slot[1].valid),
    .dec_addr     (slot[1].addr),
    .pc           (pc),
    .active       (fetch_on),
    .ret_addr     (irq_ret_addr)
  );

  assign slot[0] = '{valid: fetch_on, instr: imem_rdata, addr: pc};

  for (genvar g = 1; g < NSLOT; g++) begin : g_slot
    pf_slot_reg u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .advance (advance),
      .squash  (flush),
      .d       (slot[g-1]),
      .q       (slot[g])
    );
  end

  assign imem_addr  = pc;
  assign imem_req   = fetch_on;
  assign irq_ack    = irq_go;
  assign dec_valid  = slot[1].valid;
  assign dec_instr  = slot[1].instr;
  assign dec_addr   = slot[1].addr;
  assign ex_valid   = slot[NSLOT-1].valid;
  assign ex_instr   = slot[NSLOT-1].instr;
  assign ex_addr    = slot[NSLOT-1].addr;
  assign ex_pc_read = slot[NSLOT-1].addr + addr_t'(PC_AHEAD);
endmodule

// File: rtl/fetch_front_chk.sv
module fetch_front_chk
  import pf_pkg::*;
(
  input logic  clk,
  input logic  rst_n,
  input logic  stall,
  input addr_t imem_addr,
  input logic  redir_valid,
  input addr_t redir_target,
  input logic  irq_mask,
  input addr_t irq_vector,
  input logic  irq_ack,
  input logic  dec_valid,
  input addr_t dec_addr,
  input logic  ex_valid,
  input addr_t ex_addr,
  input addr_t ex_pc_read
);
  a_r2_word_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    imem_addr[ALIGN_BITS-1:0] == '0);

  a_r3_pc_read_ahead: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_valid && !stall && !(redir_valid && ex_valid) && !irq_ack)
      |=> (ex_valid && ex_pc_read == imem_addr));

  a_r4_redirect_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (redir_valid && ex_valid && !stall && !irq_ack)
      |=> (!ex_valid && !dec_valid && imem_addr == word_align($past(redir_target))));

  a_r6_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ack |=> (!ex_valid && !dec_valid && imem_addr == word_align($past(irq_vector))));

  a_r7_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> !irq_ack);

  a_r9_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> ($stable(imem_addr) && $stable(ex_valid) && $stable(dec_valid)
               && $stable(ex_addr) && $stable(dec_addr)));

  a_r9_no_ack_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> !irq_ack);
endmodule

bind fetch_front fetch_front_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .stall        (stall),
  .imem_addr    (imem_addr),
  .redir_valid  (redir_valid),
  .redir_target (redir_target),
  .irq_mask     (irq_mask),
  .irq_vector   (irq_vector),
  .irq_ack      (irq_ack),
  .dec_valid    (dec_valid),
  .dec_addr     (dec_addr),
  .ex_valid     (ex_valid),
  .ex_addr      (ex_addr),
  .ex_pc_read   (ex_pc_read)
);

// File: tb/fetch_front_bench.sv
module fetch_front_bench;
  logic        clk, rst_n, stall;
  logic [31:0] imem_addr, imem_rdata, redir_target, irq_vector, irq_ret_addr;
  logic [31:0] dec_instr, dec_addr, ex_instr, ex_addr, ex_pc_read;
  logic        imem_req, redir_valid, irq, irq_mask, irq_ack, dec_valid, ex_valid;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  fetch_front u_fetch_front (
    .clk(clk), .rst_n(rst_n), .stall(stall),
    .imem_addr(imem_addr), .imem_req(imem_req), .imem_rdata(imem_rdata),
    .redir_valid(redir_valid), .redir_target(redir_target),
    .irq(irq), .irq_mask(irq_mask), .irq_vector(irq_vector),
    .irq_ack(irq_ack), .irq_ret_addr(irq_ret_addr),
    .dec_valid(dec_valid), .dec_instr(dec_instr), .dec_addr(dec_addr),
    .ex_valid(ex_valid), .ex_instr(ex_instr), .ex_addr(ex_addr),
    .ex_pc_read(ex_pc_read)
  );

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return a * 32'd3 + 32'h1234_0001;
  endfunction

  assign imem_rdata = mem_word(imem_addr);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; stall = 1'b0; redir_valid = 1'b0; redir_target = '0;
    irq = 1'b0; irq_mask = 1'b0; irq_vector = '0;
    repeat (3) @(posedge clk);
    #1;
    chk1("R1 ex_valid in reset", ex_valid, 1'b0);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] tgt, ta;
    logic [31:0] targets [4];
    targets[0] = 32'h0000_0100; targets[1] = 32'h0000_0203;
    targets[2] = 32'h0000_03FE; targets[3] = 32'hFFFF_FFF1;

    // R1 R2 R3: free run from reset
    do_reset();
    chk1("R1 dec_valid after release", dec_valid, 1'b0);
    chk("R1 imem_addr after release", imem_addr, 32'h0);
    for (int k = 1; k <= 14; k++) begin
      step();
      chk("R2 sequential fetch", imem_addr, 32'(4 * (k - 1)));
      if (k == 1) chk1("R1 ex invalid edge1", ex_valid, 1'b0);
      if (k == 2) begin
        chk1("R1 dec valid edge2", dec_valid, 1'b1);
        chk("R1 dec addr edge2", dec_addr, 32'h0);
        chk1("R1 ex invalid edge2", ex_valid, 1'b0);
      end
      if (k >= 3) begin
        chk1("R1 ex valid", ex_valid, 1'b1);
        chk("R1 ex addr", ex_addr, 32'(4 * (k - 3)));
        chk("R3 pc read", ex_pc_read, 32'(4 * (k - 3) + 8));
        chk("R5 ex instr", ex_instr, mem_word(32'(4 * (k - 3))));
      end
    end

    // R4 R5 R10 R2: redirect sweep
    for (int i = 0; i < 4; i++) begin
      tgt = targets[i];
      ta  = {tgt[31:2], 2'b00};
      do_reset();
      repeat (4) step();
      redir_valid = 1'b1; redir_target = tgt;
      step();
      chk("R4 R2 fetch at aligned target", imem_addr, ta);
      chk1("R4 ex flushed", ex_valid, 1'b0);
      chk1("R4 dec flushed", dec_valid, 1'b0);
      redir_target = 32'h0000_0040;   // ex_valid is 0 here: must be ignored (R10)
      step();
      redir_valid = 1'b0;
      chk("R10 redirect ignored without ex_valid", imem_addr, ta + 32'd4);
      chk1("R5 target in decode", dec_valid, 1'b1);
      chk("R5 decode addr", dec_addr, ta);
      chk1("R5 ex still empty", ex_valid, 1'b0);
      step();
      chk1("R5 target in execute", ex_valid, 1'b1);
      chk("R5 ex addr", ex_addr, ta);
      chk("R5 ex instr", ex_instr, mem_word(ta));
      chk("R3 pc read after redirect", ex_pc_read, ta + 32'd8);
    end

    // R6: interrupt with decode full
    do_reset();
    repeat (5) step();
    irq = 1'b1; irq_vector = 32'h0000_001A;
    #1;
    chk1("R6 irq_ack", irq_ack, 1'b1);
    chk("R6 return addr from decode", irq_ret_addr, 32'h0000_000C);
    step();
    irq = 1'b0;
    chk("R6 fetch at vector", imem_addr, 32'h0000_0018);
    chk1("R6 ex flushed", ex_valid, 1'b0);
    chk1("R6 dec flushed", dec_valid, 1'b0);
    step(); step();
    chk("R6 handler in execute", ex_addr, 32'h0000_0018);

    // R7: masked interrupt
    do_reset();
    repeat (5) step();
    irq = 1'b1; irq_mask = 1'b1; irq_vector = 32'h0000_0500;
    #1;
    chk1("R7 no ack when masked", irq_ack, 1'b0);
    step();
    chk1("R7 ex still valid", ex_valid, 1'b1);
    chk("R7 ex advances", ex_addr, 32'h0000_000C);
    chk("R7 fetch sequential", imem_addr, 32'h0000_0014);
    irq = 1'b0; irq_mask = 1'b0;

    // R6: interrupt with decode empty takes fetch address
    do_reset();
    repeat (4) step();
    redir_valid = 1'b1; redir_target = 32'h0000_0080;
    step();
    redir_valid = 1'b0;
    irq = 1'b1; irq_vector = 32'h0000_0600;
    #1;
    chk1("R6 ack with decode empty", irq_ack, 1'b1);
    chk("R6 return addr from fetch", irq_ret_addr, 32'h0000_0080);
    step();
    irq = 1'b0;
    chk("R6 vector after empty decode", imem_addr, 32'h0000_0600);

    // R8: redirect and interrupt together
    do_reset();
    repeat (5) step();
    redir_valid = 1'b1; redir_target = 32'h0000_0207;
    irq = 1'b1; irq_vector = 32'h0000_0700;
    #1;
    chk1("R8 ack", irq_ack, 1'b1);
    chk("R8 return is redirect target", irq_ret_addr, 32'h0000_0204);
    step();
    redir_valid = 1'b0; irq = 1'b0;
    chk("R8 fetch at vector", imem_addr, 32'h0000_0700);
    chk1("R8 ex flushed", ex_valid, 1'b0);

    // R9: stall holds and blocks redirect and interrupt
    do_reset();
    repeat (5) step();
    stall = 1'b1; redir_valid = 1'b1; redir_target = 32'h0000_0300;
    irq = 1'b1; irq_vector = 32'h0000_0800;
    #1;
    chk1("R9 no ack while stalled", irq_ack, 1'b0);
    for (int s = 0; s < 3; s++) begin
      step();
      chk("R9 fetch held", imem_addr, 32'h0000_0010);
      chk("R9 ex addr held", ex_addr, 32'h0000_0008);
      chk1("R9 ex valid held", ex_valid, 1'b1);
      chk("R9 dec addr held", dec_addr, 32'h0000_000C);
      chk1("R9 dec valid held", dec_valid, 1'b1);
    end
    stall = 1'b0; redir_valid = 1'b0; irq = 1'b0;
    step();
    chk("R9 resumes in sequence ex", ex_addr, 32'h0000_000C);
    chk("R9 resumes in sequence fetch", imem_addr, 32'h0000_0014);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule